// File: doc/BRIEF.md
# Static Memory Access Sequencer with Wait Handling

This block carries out a single read or write on an asynchronous static-memory bus. A host raises a request together with a direction bit, an address and write data. The sequencer then walks three phases: setup, pulse and hold. Each phase lasts a number of clock cycles given by the length inputs. During these phases it drives chip-select, a read strobe and a write strobe, all active low. When the hold phase ends, it returns to idle and pulses an acknowledge for one cycle. For a read, the captured data is presented at that point.

Two mode bits are latched with each request. They choose which signal marks the timed window. With a mode bit at 1, the strobe for that direction is low only during the pulse phase, and chip-select covers all three phases. With the mode bit at 0, the roles swap: chip-select is low only during the pulse phase, and the strobe covers all three phases.

An active-low wait input from the device passes through a two-flop synchronizer. A two-bit wait-mode input selects how it acts:
- ignored (codes 0 and 1);
- freeze (code 2): the pulse phase counter pauses while wait is low;
- ready (code 3): wait is sampled at the last pulse cycle, and the pulse is held there until wait is high.

Wait acts only inside the pulse phase. Because of the synchronizer, a level driven on the wait pin affects the sequencer two clock edges later. In ready mode, the device must therefore pull wait low at least two cycles before the final pulse cycle.

Top module: `sbus_seq`

## Requirements
- R1: For a read with `rd_by_strobe`=1, `bus_oe_n` is low only during the pulse phase and `bus_cs_n` is low for the whole access. With `rd_by_strobe`=0, `bus_cs_n` is low only during the pulse phase and `bus_oe_n` is low for the whole access. `bus_we_n` stays high during a read.
- R2: For a write with `wr_by_strobe`=1, `bus_we_n` is low only during the pulse phase and `bus_cs_n` is low for the whole access. With `wr_by_strobe`=0, `bus_cs_n` is low only during the pulse phase and `bus_we_n` is low for the whole access. `bus_oe_n` stays high during a write, and the two strobes are never low together.
- R3: Without wait stretching, an access occupies `setup_len` + max(`pulse_len`,1) + `hold_len` cycles. A setup or hold length of 0 skips that phase, and a pulse length of 0 is treated as 1.
- R4: With `wait_mode` 0 (ignore) or 1 (reserved, handled as ignore), `bus_wait_n` has no effect on any access length.
- R5: With `wait_mode` 2 (freeze), each synchronized cycle of `bus_wait_n` low during the pulse phase stretches the pulse by one cycle. The access then resumes where it paused.
- R6: `bus_wait_n` has no effect while the access is in its setup or hold phase.
- R7: With `wait_mode` 3 (ready), wait is examined only at the last pulse cycle. If it is low there, the pulse is extended until the synchronized wait is high. A low level that ends before the last pulse cycle has no effect.
- R8: A level applied on `bus_wait_n` is first used by the sequencer at the second rising clock edge after it is applied (two-flop synchronizer).
- R9: `cfg_err` is 1 exactly when `wait_mode` is 2 or 3 and `hold_len` is 0.
- R10: For a read, `rsp_rdata` takes the value of `bus_din` at the clock edge that ends the pulse phase, including a pulse end delayed by wait.
- R11: `ack` is high for exactly one cycle after the last active cycle. A request is accepted only when the block is idle and `ack` is low.
- R12: After reset all strobes and chip-select are high, `ack` is 0, `bus_dout_en` is 0 and `rsp_rdata` is 0.
- R13: During an access `bus_addr` carries the request address. During a write `bus_dout` carries the write data and `bus_dout_en` is 1 for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Access request, held until `ack` |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| rsp_rdata | output | DW | Read data captured at the end of the pulse |
| ack | output | 1 | One-cycle completion pulse |
| rd_by_strobe | input | 1 | Reads timed by read strobe (1) or chip-select (0) |
| wr_by_strobe | input | 1 | Writes timed by write strobe (1) or chip-select (0) |
| wait_mode | input | 2 | 0/1 ignore, 2 freeze, 3 ready |
| setup_len | input | CW | Setup phase cycles |
| pulse_len | input | CW | Pulse phase cycles (0 acts as 1) |
| hold_len | input | CW | Hold phase cycles |
| cfg_err | output | 1 | Wait enabled with zero hold length |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_addr | output | AW | Bus address |
| bus_dout | output | DW | Bus write data |
| bus_dout_en | output | 1 | Write data drive enable |
| bus_din | input | DW | Bus read data |
| bus_wait_n | input | 1 | Asynchronous wait from the device, active low |

## Verification
The bench builds the block with 16-bit address and data, a 6-bit length width and a two-stage synchronizer. The six-bit lengths allow phase lengths of zero, one and several cycles in one table. The fixed two-edge wait latency lets the bench predict each stretch exactly from the cycle at which it drops the wait pin. The bench changes `bus_din` every cycle, so the read value it gets back names the very edge at which the pulse ended.

// File: rtl/sbus_pkg.sv
// Shared types for the static-bus access sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sbus_pkg;

    // Phase of the current access.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_PULSE = 2'd2,
        PH_HOLD  = 2'd3
    } phase_e;

    // Wait-mode codes that do something; the other two codes ignore wait.
    localparam logic [1:0] WM_FREEZE = 2'd2;
    localparam logic [1:0] WM_READY  = 2'd3;

    // Per-access settings latched when a request is taken.
    typedef struct packed {
        logic       is_wr;
        logic       rd_strobe;
        logic       wr_strobe;
        logic [1:0] wmode;
    } acc_mode_t;

endpackage

// File: rtl/sbus_wait_sync.sv
// Multi-stage synchronizer for the asynchronous active-low wait input.
// Assumes: STAGES >= 2; resets to the deasserted (high) level.
module sbus_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_n,
    output logic sync_n
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First stage samples the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b1;
                else        chain[0] <= async_n;
            end
        end else begin : g_next
            // Later stages shift the sampled level along.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign sync_n = chain[STAGES-1];

endmodule

// File: rtl/sbus_phase_ctrl.sv
// Phase sequencer: counts setup, pulse and hold cycles and applies the wait
// policy during the pulse phase. Raises ack for one cycle at completion.
// Assumes: start only in PH_IDLE; wmode valid from the cycle after start.
module sbus_phase_ctrl
    import sbus_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    wmode,
    input  logic [CW-1:0] setup_len,
    input  logic [CW-1:0] pulse_len,
    input  logic [CW-1:0] hold_len,
    input  logic          wait_ok,
    output phase_e        phase,
    output logic [CW-1:0] cnt,
    output logic          pulse_end,
    output logic          ack
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] pulse_eff;
    logic [CW-1:0] pulse_q;
    logic [CW-1:0] hold_q;
    logic          freeze_stall;
    logic          ready_stall;
    phase_e        phase_d;
    logic [CW-1:0] cnt_d;
    logic          ack_d;

    assign pulse_eff = (pulse_len == '0) ? ONE : pulse_len;

    // Stall conditions, both limited to the pulse phase.
    always_comb begin
        freeze_stall = (phase == PH_PULSE) && (wmode == WM_FREEZE) && !wait_ok;
        ready_stall  = (phase == PH_PULSE) && (wmode == WM_READY) &&
                       (cnt == '0) && !wait_ok;
        pulse_end    = (phase == PH_PULSE) && (cnt == '0) &&
                       !freeze_stall && !ready_stall;
    end

    // Latch the pulse and hold lengths when an access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= ONE;
            hold_q  <= '0;
        end else if (start) begin
            pulse_q <= pulse_eff;
            hold_q  <= hold_len;
        end
    end

    // Next phase, count and completion flag.
    always_comb begin
        phase_d = phase;
        cnt_d   = cnt;
        ack_d   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    if (setup_len != '0) begin
                        phase_d = PH_SETUP;
                        cnt_d   = setup_len - ONE;
                    end else begin
                        phase_d = PH_PULSE;
                        cnt_d   = pulse_eff - ONE;
                    end
                end
            end
            PH_SETUP: begin
                if (cnt == '0) begin
                    phase_d = PH_PULSE;
                    cnt_d   = pulse_q - ONE;
                end else begin
                    cnt_d = cnt - ONE;
                end
            end
            PH_PULSE: begin
                if (freeze_stall || ready_stall) begin
                    cnt_d = cnt;
                end else if (cnt == '0) begin
                    if (hold_q != '0) begin
                        phase_d = PH_HOLD;
                        cnt_d   = hold_q - ONE;
                    end else begin
                        phase_d = PH_IDLE;
                        ack_d   = 1'b1;
                    end
                end else begin
                    cnt_d = cnt - ONE;
                end
            end
            PH_HOLD: begin
                if (cnt == '0) begin
                    phase_d = PH_IDLE;
                    ack_d   = 1'b1;
                end else begin
                    cnt_d = cnt - ONE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            ack   <= 1'b0;
        end else begin
            phase <= phase_d;
            cnt   <= cnt_d;
            ack   <= ack_d;
        end
    end

endmodule

// File: rtl/sbus_pin_drv.sv
// Pin driver: latches the request, decodes chip-select and strobes from the
// phase and timing-mode bits, and captures read data at the end of the pulse.
// Assumes: start only in PH_IDLE; pulse_end is high for one cycle per access.
module sbus_pin_drv
    import sbus_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  acc_mode_t     mode_in,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  phase_e        phase,
    input  logic          pulse_end,
    input  logic [DW-1:0] bus_din,
    output acc_mode_t     mode_q,
    output logic [DW-1:0] rdata,
    output logic          bus_cs_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic          active;
    logic          in_pulse;
    logic          ctrl_strobe;

    // Capture the request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            mode_q  <= mode_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    // Capture read data on the edge that closes the read pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                        rdata <= '0;
        else if (pulse_end && !mode_q.is_wr) rdata <= bus_din;
    end

    // Decode the bus control pins from phase and timing mode.
    always_comb begin
        active      = (phase != PH_IDLE);
        in_pulse    = (phase == PH_PULSE);
        ctrl_strobe = mode_q.is_wr ? mode_q.wr_strobe : mode_q.rd_strobe;
        bus_cs_n    = !(ctrl_strobe ? active : in_pulse);
        bus_oe_n    = !(active && !mode_q.is_wr &&
                        (mode_q.rd_strobe ? in_pulse : 1'b1));
        bus_we_n    = !(active && mode_q.is_wr &&
                        (mode_q.wr_strobe ? in_pulse : 1'b1));
        bus_dout_en = active && mode_q.is_wr;
        bus_addr    = addr_q;
        bus_dout    = wdata_q;
    end

endmodule

// File: rtl/sbus_seq.sv
// Top of the static-bus access sequencer. Takes a request when idle, runs
// one setup/pulse/hold access with the chosen controlling signal and wait
// policy, and acknowledges it for one cycle.
// Assumes: host holds req until ack and drops it on seeing ack.
module sbus_seq
    import sbus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int CW          = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          ack,
    input  logic          rd_by_strobe,
    input  logic          wr_by_strobe,
    input  logic [1:0]    wait_mode,
    input  logic [CW-1:0] setup_len,
    input  logic [CW-1:0] pulse_len,
    input  logic [CW-1:0] hold_len,
    output logic          cfg_err,
    output logic          bus_cs_n,
    output logic          bus_oe_n,
    output logic          bus_we_n,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_dout,
    output logic          bus_dout_en,
    input  logic [DW-1:0] bus_din,
    input  logic          bus_wait_n
);
    phase_e        phase;
    logic [CW-1:0] cnt;
    logic          pulse_end;
    logic          wait_ok;
    logic          start;
    acc_mode_t     mode_in;
    acc_mode_t     mode_q;
    logic [1:0]    wmode_q;

    // Accept a request only when idle and not acknowledging.
    always_comb begin
        start   = req && (phase == PH_IDLE) && !ack;
        mode_in = '{is_wr: req_wr, rd_strobe: rd_by_strobe,
                    wr_strobe: wr_by_strobe, wmode: wait_mode};
        wmode_q = mode_q.wmode;
        cfg_err = wait_mode[1] && (hold_len == '0);
    end

    sbus_wait_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (bus_wait_n),
        .sync_n  (wait_ok)
    );

    sbus_phase_ctrl #(.CW(CW)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wmode     (wmode_q),
        .setup_len (setup_len),
        .pulse_len (pulse_len),
        .hold_len  (hold_len),
        .wait_ok   (wait_ok),
        .phase     (phase),
        .cnt       (cnt),
        .pulse_end (pulse_end),
        .ack       (ack)
    );

    sbus_pin_drv #(.AW(AW), .DW(DW)) i_pins (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .mode_in     (mode_in),
        .addr_in     (req_addr),
        .wdata_in    (req_wdata),
        .phase       (phase),
        .pulse_end   (pulse_end),
        .bus_din     (bus_din),
        .mode_q      (mode_q),
        .rdata       (rsp_rdata),
        .bus_cs_n    (bus_cs_n),
        .bus_oe_n    (bus_oe_n),
        .bus_we_n    (bus_we_n),
        .bus_addr    (bus_addr),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en)
    );

endmodule

// File: rtl/sbus_seq_chk.sv
// Assertion checker for sbus_seq, attached by bind below.
// Assumes: the top exposes phase, cnt, wait_ok and wmode_q.
module sbus_seq_chk
    import sbus_pkg::*;
#(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          req,
    input logic          bus_cs_n,
    input logic          bus_oe_n,
    input logic          bus_we_n,
    input logic          bus_dout_en,
    input phase_e        phase,
    input logic [CW-1:0] cnt,
    input logic          wait_ok,
    input logic [1:0]    wmode_q
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R11

    AST_ACK_AFTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(phase) != PH_IDLE); // R11

    AST_ACK_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (bus_cs_n && bus_oe_n && bus_we_n)); // R11

    AST_NO_RESTART_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req) |=> phase == PH_IDLE); // R11

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_oe_n && !bus_we_n)); // R2

    AST_DOUT_COVERED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dout_en |-> (!bus_we_n || !bus_cs_n)); // R13

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && wmode_q == WM_FREEZE && !wait_ok)
        |=> (phase == PH_PULSE && $stable(cnt))); // R5

    AST_READY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PULSE && wmode_q == WM_READY && cnt == '0 && !wait_ok)
        |=> phase == PH_PULSE); // R7

endmodule

bind sbus_seq sbus_seq_chk #(.CW(CW)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .req         (req),
    .bus_cs_n    (bus_cs_n),
    .bus_oe_n    (bus_oe_n),
    .bus_we_n    (bus_we_n),
    .bus_dout_en (bus_dout_en),
    .phase       (phase),
    .cnt         (cnt),
    .wait_ok     (wait_ok),
    .wmode_q     (wmode_q)
);

// File: tb/test_sbus_seq.sv
module test_sbus_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 6;

    typedef struct packed {
        logic       wr;
        logic       rsel;
        logic       wsel;
        logic [1:0] wm;
        logic [5:0] s;
        logic [5:0] p;
        logic [5:0] h;
        logic [7:0] jw;
        logic [7:0] wl;
        logic [7:0] ext;
    } vec_t;

    localparam int NV = 13;
    // wr rsel wsel wm s p h jw wl ext
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 2'd0, 6'd2, 6'd3, 6'd1, 8'd0, 8'd0, 8'd0}, // R1 R3
        '{1'b1, 1'b0, 1'b0, 2'd0, 6'd1, 6'd2, 6'd2, 8'd0, 8'd0, 8'd0}, // R2
        '{1'b1, 1'b0, 1'b1, 2'd0, 6'd0, 6'd1, 6'd0, 8'd0, 8'd0, 8'd0}, // R3
        '{1'b0, 1'b0, 1'b0, 2'd0, 6'd1, 6'd0, 6'd1, 8'd0, 8'd0, 8'd0}, // R3
        '{1'b0, 1'b1, 1'b0, 2'd2, 6'd2, 6'd4, 6'd1, 8'd2, 8'd3, 8'd3}, // R5 R8
        '{1'b0, 1'b1, 1'b0, 2'd2, 6'd4, 6'd2, 6'd1, 8'd1, 8'd2, 8'd0}, // R6
        '{1'b1, 1'b0, 1'b1, 2'd2, 6'd1, 6'd2, 6'd4, 8'd5, 8'd2, 8'd0}, // R6
        '{1'b0, 1'b1, 1'b0, 2'd0, 6'd1, 6'd3, 6'd1, 8'd1, 8'd4, 8'd0}, // R4
        '{1'b0, 1'b1, 1'b0, 2'd1, 6'd1, 6'd3, 6'd1, 8'd1, 8'd4, 8'd0}, // R4
        '{1'b1, 1'b0, 1'b1, 2'd3, 6'd1, 6'd2, 6'd1, 8'd1, 8'd5, 8'd5}, // R7
        '{1'b0, 1'b1, 1'b0, 2'd3, 6'd1, 6'd5, 6'd1, 8'd1, 8'd2, 8'd0}, // R7
        '{1'b0, 1'b0, 1'b0, 2'd3, 6'd2, 6'd2, 6'd2, 8'd2, 8'd3, 8'd3}, // R7 R10
        '{1'b1, 1'b0, 1'b0, 2'd2, 6'd0, 6'd2, 6'd1, 8'd0, 8'd2, 8'd2}  // R5 R8
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic          req_wr = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic          ack;
    logic          rd_by_strobe = 1'b0;
    logic          wr_by_strobe = 1'b0;
    logic [1:0]    wait_mode = 2'd0;
    logic [CW-1:0] setup_len = '0;
    logic [CW-1:0] pulse_len = '0;
    logic [CW-1:0] hold_len = '0;
    logic          cfg_err;
    logic          bus_cs_n;
    logic          bus_oe_n;
    logic          bus_we_n;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_dout;
    logic          bus_dout_en;
    logic [DW-1:0] bus_din = '0;
    logic          bus_wait_n = 1'b1;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbus_seq #(.AW(AW), .DW(DW), .CW(CW), .SYNC_STAGES(2)) i_sbus_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .ack(ack), .rd_by_strobe(rd_by_strobe), .wr_by_strobe(wr_by_strobe),
        .wait_mode(wait_mode), .setup_len(setup_len), .pulse_len(pulse_len),
        .hold_len(hold_len), .cfg_err(cfg_err), .bus_cs_n(bus_cs_n),
        .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_dout_en(bus_dout_en), .bus_din(bus_din),
        .bus_wait_n(bus_wait_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Run one table access; keep_req holds req one cycle past ack.
    task automatic run_vec(input int idx, input bit keep_req);
        vec_t v = VECS[idx];
        int pe = (v.p == 0) ? 1 : int'(v.p);
        int tot = int'(v.s) + pe + int'(v.h) + int'(v.ext);
        int plen = pe + int'(v.ext);
        int edge_end = int'(v.s) + pe + int'(v.ext);
        bit ctrl = v.wr ? v.wsel : v.rsel;
        logic [DW-1:0] base = DW'(16'hA000 + 16'h0100 * idx);
        logic [AW-1:0] adr = AW'(16'h1200 + idx);
        logic [DW-1:0] wd = DW'(16'h5A00 + idx);
        int busy = 0, cs_lo = 0, oe_lo = 0, we_lo = 0, den = 0, bad_bus = 0;
        bit got_ack = 1'b0;
        @(negedge clk);
        req = 1'b1; req_wr = v.wr; req_addr = adr; req_wdata = wd;
        rd_by_strobe = v.rsel; wr_by_strobe = v.wsel; wait_mode = v.wm;
        setup_len = v.s; pulse_len = v.p; hold_len = v.h;
        bus_wait_n = !(v.wl != 0 && v.jw == 0);
        bus_din = base;
        for (int j = 1; j < 200; j++) begin
            @(negedge clk);
            if (ack) begin got_ack = 1'b1; break; end
            if (!bus_cs_n || !bus_oe_n || !bus_we_n) begin
                busy++;
                if (bus_addr != adr) bad_bus++;
                if (v.wr && bus_dout != wd) bad_bus++;
            end
            if (!bus_cs_n) cs_lo++;
            if (!bus_oe_n) oe_lo++;
            if (!bus_we_n) we_lo++;
            if (bus_dout_en) den++;
            bus_wait_n = !(j >= int'(v.jw) && j < int'(v.jw) + int'(v.wl));
            bus_din = base + DW'(j);
        end
        if (!keep_req) req = 1'b0;
        bus_wait_n = 1'b1;
        chk(got_ack, $sformatf("R11 vec%0d ack seen", idx), got_ack, 1);
        chk(busy == tot, $sformatf("R3 R4 R5 R6 R7 R8 vec%0d access cycles", idx), busy, tot);
        chk(cs_lo == (ctrl ? tot : plen), $sformatf("R1 R2 vec%0d cs low cycles", idx),
            cs_lo, ctrl ? tot : plen);
        if (v.wr) begin
            chk(we_lo == (ctrl ? plen : tot), $sformatf("R2 vec%0d we low cycles", idx),
                we_lo, ctrl ? plen : tot);
            chk(oe_lo == 0, $sformatf("R2 vec%0d oe during write", idx), oe_lo, 0);
            chk(den == tot, $sformatf("R13 vec%0d dout_en cycles", idx), den, tot);
        end else begin
            chk(oe_lo == (ctrl ? plen : tot), $sformatf("R1 vec%0d oe low cycles", idx),
                oe_lo, ctrl ? plen : tot);
            chk(we_lo == 0, $sformatf("R1 vec%0d we during read", idx), we_lo, 0);
            chk(rsp_rdata == base + DW'(edge_end), $sformatf("R10 vec%0d read data", idx),
                rsp_rdata, base + DW'(edge_end));
        end
        chk(bad_bus == 0, $sformatf("R13 vec%0d address/data on bus", idx), bad_bus, 0);
        @(negedge clk);
        chk(ack == 1'b0, $sformatf("R11 vec%0d ack one cycle", idx), ack, 0);
        if (keep_req) begin
            chk(bus_cs_n && bus_oe_n && bus_we_n,
                $sformatf("R11 vec%0d no accept during ack", idx), bus_cs_n, 1);
            req = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state.
        chk(bus_cs_n && bus_oe_n && bus_we_n, "R12 pins idle in reset", bus_cs_n, 1);
        chk(!ack && !bus_dout_en, "R12 ack and dout_en low", ack, 0);
        chk(rsp_rdata == '0, "R12 read data zero", rsp_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_cs_n && bus_oe_n && bus_we_n && !ack, "R12 idle after reset", bus_cs_n, 1);

        for (int i = 0; i < NV; i++) run_vec(i, 1'b0);

        // R11: request still high during ack is not re-accepted.
        run_vec(0, 1'b1);

        // R9: configuration error flag.
        wait_mode = 2'd2; hold_len = '0; #1;
        chk(cfg_err == 1'b1, "R9 freeze with zero hold", cfg_err, 1);
        wait_mode = 2'd3; #1;
        chk(cfg_err == 1'b1, "R9 ready with zero hold", cfg_err, 1);
        wait_mode = 2'd1; #1;
        chk(cfg_err == 1'b0, "R9 reserved with zero hold", cfg_err, 0);
        wait_mode = 2'd2; hold_len = 6'd1; #1;
        chk(cfg_err == 1'b0, "R9 freeze with hold 1", cfg_err, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule